// File: doc/BRIEF.md
# Glitch-Filtered Pin Edge Interrupt Controller

This block watches eight port pins and raises one shared interrupt request when a qualified edge shows up on any of them. Each pin is first brought into the clock domain by a short synchronizer chain. It then passes through a digital pulse-width filter, which only changes its output level after the new level has held for a fixed number of filter ticks. A change of the filtered level in the direction chosen for that pin sets a sticky per-pin flag. Software clears a flag by writing a one to its bit.

The filter has two timebases. In normal running and in wait mode it counts the bus-rate tick `runTick`. In stop mode it counts a separate slow tick `stopTick`, so short glitches are still rejected while the fast clock is mostly idle. The shared request also acts as a wake-up request whenever the core is in stop or wait mode.

A pin takes part in detection when its digital input buffer is enabled, or when the pin is driven as an output. A pin that is neither keeps its filter frozen.

Top module: `portEdgeIrq`

## Requirements
- R1: After reset, `flags` is 0, and both `irqReq` and `wakeReq` are 0.
- R2: With `runTick` high on every cycle and `stopMode` low, a pin pulse that lasts 3 clock cycles or less never sets its flag.
- R3: With `runTick` high on every cycle, a pin level held for 4 cycles or more is accepted. A qualifying edge sets its flag on the 6th rising clock edge after the pin changes: 2 synchronizer stages plus 4 filter ticks.
- R4: When `edgeRising[i]` is 1, only a rise of pin i's filtered level sets `flags[i]`. When it is 0, only a fall does.
- R5: `irqReq` is 1 exactly when some bit is set in both `flags` and `irqEnable`. A flag still sets while its enable bit is 0.
- R6: A cycle with `clrWrEn` high clears every flag whose `clrData` bit is 1 and leaves the other flags unchanged. If an edge on a pin is accepted in the same cycle as its clear, the flag stays set.
- R7: When `stopMode` is 1, the filter advances only on `stopTick` and ignores `runTick`. A level that spans 3 stop ticks is rejected, and one that spans 4 stop ticks is accepted.
- R8: `wakeReq` equals `irqReq` while `stopMode` or `waitMode` is 1, and is 0 otherwise.
- R9: Pin i is tracked while `digInEn[i]` or `outMode[i]` is 1. While both are 0, pulses on pin i of any length leave its filtered level and its flag unchanged.
- R10: Pins are independent. The flag of each pin depends only on that pin's own pulses and settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 8 | Pad levels of the port pins |
| digInEn | input | 8 | Per-pin digital input buffer enable |
| outMode | input | 8 | Per-pin output direction (1 = driven as output) |
| irqEnable | input | 8 | Per-pin interrupt enable |
| edgeRising | input | 8 | Per-pin edge select (1 = rising, 0 = falling) |
| clrWrEn | input | 1 | Write strobe for the flag clear |
| clrData | input | 8 | Write-one-to-clear data for the flags |
| runTick | input | 1 | Filter tick for run and wait mode |
| stopTick | input | 1 | Slow filter tick for stop mode |
| stopMode | input | 1 | Core is in stop mode |
| waitMode | input | 1 | Core is in wait mode |
| flags | output | 8 | Sticky per-pin edge flags |
| irqReq | output | 1 | Shared interrupt request |
| wakeReq | output | 1 | Wake-up request to the core |

## Verification
The checker assumes three things about the inputs. The mode and tick inputs are synchronous to `clk`. `stopTick` is a one-cycle pulse. The sensing controls are known from the first clock edge onward. The bench drives every input only on the falling clock edge. It raises `stopTick` for exactly one cycle out of every eight. Between random rounds it holds each pin idle long enough for the filter to settle, so each pulse is judged on its own width.

// File: rtl/portirq_pkg.sv
package portirq_pkg;

  // Number of port pins handled by one controller instance
  localparam int PIN_COUNT = 8;

  // Strobes passed from the control module to the datapath each cycle
  typedef struct packed {
    logic                 filtTick;   // filter counters may advance
    logic [PIN_COUNT-1:0] senseMask;  // pins currently tracked
    logic [PIN_COUNT-1:0] clrMask;    // flags to clear this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/irqControl.sv
module irqControl
  import portirq_pkg::*;
(
  input  logic                 runTick,
  input  logic                 stopTick,
  input  logic                 stopMode,
  input  logic                 waitMode,
  input  logic [PIN_COUNT-1:0] digInEn,
  input  logic [PIN_COUNT-1:0] outMode,
  input  logic                 clrWrEn,
  input  logic [PIN_COUNT-1:0] clrData,
  input  logic [PIN_COUNT-1:0] flags,
  input  logic [PIN_COUNT-1:0] irqEnable,
  output ctrlStrobes_t         strobes,
  output logic                 irqReq,
  output logic                 wakeReq
);

  logic lowPower;
  logic anyPending;

  // The filter timebase follows the core's power state
  always_comb begin
    strobes.filtTick  = stopMode ? stopTick : runTick;
    strobes.senseMask = digInEn | outMode;
    strobes.clrMask   = clrWrEn ? clrData : '0;
  end

  assign anyPending = |(flags & irqEnable);
  assign lowPower   = stopMode | waitMode;
  assign irqReq     = anyPending;
  assign wakeReq    = anyPending & lowPower;

endmodule

// File: rtl/pinFilterPath.sv
module pinFilterPath
  import portirq_pkg::*;
#(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] edgeRising,
  input  ctrlStrobes_t         strobes,
  output logic [PIN_COUNT-1:0] filtLevel,
  output logic [PIN_COUNT-1:0] flags
);

  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   syncBit;
    logic [CNT_W-1:0]       stableCnt;
    logic                   filtQ;
    logic                   differs;
    logic                   acceptHit;
    logic                   edgeHit;
    logic                   flagQ;

    // Synchronizer chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn[i]};
    end
    assign syncBit = syncQ[SYNC_STAGES-1];

    // A new level is taken only after FILT_LEN ticks without reverting
    assign differs   = syncBit != filtQ;
    assign acceptHit = strobes.senseMask[i] & strobes.filtTick & differs &
                       (stableCnt == CNT_LAST);
    assign edgeHit   = acceptHit & (syncBit == edgeRising[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stableCnt <= '0;
        filtQ     <= 1'b0;
      end else if (!strobes.senseMask[i]) begin
        stableCnt <= '0;
      end else if (strobes.filtTick) begin
        if (!differs) begin
          stableCnt <= '0;
        end else if (stableCnt == CNT_LAST) begin
          stableCnt <= '0;
          filtQ     <= syncBit;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end

    // Sticky flag: a set in the same cycle beats the clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ <= 1'b0;
      else       flagQ <= (flagQ & ~strobes.clrMask[i]) | edgeHit;
    end

    assign filtLevel[i] = filtQ;
    assign flags[i]     = flagQ;
  end

endmodule

// File: rtl/portEdgeIrq.sv
module portEdgeIrq
  import portirq_pkg::*;
#(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] digInEn,
  input  logic [PIN_COUNT-1:0] outMode,
  input  logic [PIN_COUNT-1:0] irqEnable,
  input  logic [PIN_COUNT-1:0] edgeRising,
  input  logic                 clrWrEn,
  input  logic [PIN_COUNT-1:0] clrData,
  input  logic                 runTick,
  input  logic                 stopTick,
  input  logic                 stopMode,
  input  logic                 waitMode,
  output logic [PIN_COUNT-1:0] flags,
  output logic                 irqReq,
  output logic                 wakeReq
);

  ctrlStrobes_t         strobes;
  logic [PIN_COUNT-1:0] filtLevel;

  irqControl u_ctrl (
    .runTick   (runTick),
    .stopTick  (stopTick),
    .stopMode  (stopMode),
    .waitMode  (waitMode),
    .digInEn   (digInEn),
    .outMode   (outMode),
    .clrWrEn   (clrWrEn),
    .clrData   (clrData),
    .flags     (flags),
    .irqEnable (irqEnable),
    .strobes   (strobes),
    .irqReq    (irqReq),
    .wakeReq   (wakeReq)
  );

  pinFilterPath #(
    .FILT_LEN    (FILT_LEN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .edgeRising (edgeRising),
    .strobes    (strobes),
    .filtLevel  (filtLevel),
    .flags      (flags)
  );

endmodule

// File: rtl/portEdgeIrqChk.sv
module portEdgeIrqChk
  import portirq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 stopMode,
  input logic                 stopTick,
  input logic                 waitMode,
  input logic [PIN_COUNT-1:0] flags,
  input logic                 irqReq,
  input logic                 wakeReq,
  input logic [PIN_COUNT-1:0] filtLevel,
  input logic [PIN_COUNT-1:0] senseMask
);

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (flags != '0));

  // R8
  wake_needs_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> irqReq);

  // R8
  no_wake_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopMode && !waitMode) |-> !wakeReq);

  // R7
  stop_tick_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !stopTick) |=> $stable(filtLevel));

  // R9
  sense_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((filtLevel ^ $past(filtLevel)) & ~$past(senseMask)) == '0);

  // R4
  flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ~$past(flags)) & ~(filtLevel ^ $past(filtLevel))) == '0);

endmodule

bind portEdgeIrq portEdgeIrqChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stopMode  (stopMode),
  .stopTick  (stopTick),
  .waitMode  (waitMode),
  .flags     (flags),
  .irqReq    (irqReq),
  .wakeReq   (wakeReq),
  .filtLevel (filtLevel),
  .senseMask (strobes.senseMask)
);

// File: tb/tb_portEdgeIrq.sv
module tb_portEdgeIrq;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] pinIn, digInEn, outMode, irqEnable, edgeRising, clrData;
  logic       clrWrEn, runTick, stopTick, stopMode, waitMode;
  logic [7:0] flags;
  logic       irqReq, wakeReq;

  int  checks = 0;
  int  failures = 0;
  int  cycCount = 0;
  bit  stopGenOn = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  portEdgeIrq dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .digInEn(digInEn), .outMode(outMode),
    .irqEnable(irqEnable), .edgeRising(edgeRising), .clrWrEn(clrWrEn),
    .clrData(clrData), .runTick(runTick), .stopTick(stopTick),
    .stopMode(stopMode), .waitMode(waitMode), .flags(flags),
    .irqReq(irqReq), .wakeReq(wakeReq)
  );

  function automatic logic [7:0] expFlags(logic [7:0] mask, int width);
    return (width >= 4) ? mask : 8'h00;
  endfunction

  function automatic logic expIrq(logic [7:0] f, logic [7:0] en);
    return |(f & en);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance n cycles; inputs change and outputs are sampled at falling edges
  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      cycCount++;
      stopTick = stopGenOn && (cycCount % 8 == 0);
    end
  endtask

  task automatic pulse(logic [7:0] mask, int width, int settle);
    pinIn = pinIn | mask;
    cyc(width);
    pinIn = pinIn & ~mask;
    cyc(settle);
  endtask

  task automatic clearFlags(logic [7:0] data);
    clrWrEn = 1'b1;
    clrData = data;
    cyc(1);
    clrWrEn = 1'b0;
    clrData = 8'h00;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; pinIn = 8'h00; digInEn = 8'hFF; outMode = 8'h00;
    irqEnable = 8'hFF; edgeRising = 8'hFF; clrWrEn = 1'b0; clrData = 8'h00;
    runTick = 1'b1; stopTick = 1'b0; stopMode = 1'b0; waitMode = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R1 reset state
    check("R1 flags", flags, 8'h00);
    check("R1 irq", irqReq, 1'b0);
    check("R1 wake", wakeReq, 1'b0);

    // R2 three-cycle glitch rejected
    pulse(8'h01, 3, 12);
    check("R2 glitch", flags, 8'h00);

    // R3 exact latency of acceptance
    pinIn[1] = 1'b1;
    cyc(5);
    check("R3 before 6th edge", flags[1], 1'b0);
    cyc(1);
    check("R3 at 6th edge", flags[1], 1'b1);
    cyc(6);
    pinIn[1] = 1'b0;
    cyc(12);
    clearFlags(8'hFF);
    check("R6 clear all", flags, 8'h00);

    // R4 falling-edge selection
    edgeRising = 8'hFB;
    pinIn[2] = 1'b1;
    cyc(12);
    check("R4 no flag on rise when falling selected", flags[2], 1'b0);
    pinIn[2] = 1'b0;
    cyc(12);
    check("R4 flag on fall", flags[2], 1'b1);
    edgeRising = 8'hFF;

    // R5 enable masking
    irqEnable = 8'hFB;
    cyc(1);
    check("R5 flag kept, irq masked", {flags[2], irqReq}, 2'b10);
    irqEnable = 8'hFF;
    cyc(1);
    check("R5 irq with enable", irqReq, 1'b1);

    // R8 wake follows irq only in low-power modes
    check("R8 no wake in run", wakeReq, 1'b0);
    waitMode = 1'b1;
    cyc(1);
    check("R8 wake in wait", wakeReq, 1'b1);
    waitMode = 1'b0;

    // R6 partial clear leaves other bits
    pulse(8'h10, 6, 12);
    clearFlags(8'h04);
    check("R6 partial clear", flags, 8'h10);
    clearFlags(8'hFF);

    // R6 set wins over same-cycle clear
    pulse(8'h01, 6, 12);
    check("R6 setup flag", flags[0], 1'b1);
    pinIn[0] = 1'b1;
    cyc(5);
    clrWrEn = 1'b1; clrData = 8'h01;
    cyc(1);
    clrWrEn = 1'b0; clrData = 8'h00;
    check("R6 set beats clear", flags[0], 1'b1);
    cyc(6);
    pinIn[0] = 1'b0;
    cyc(12);
    clearFlags(8'hFF);

    // R9 untracked pin ignored, output mode tracked
    digInEn = 8'hF7;
    pulse(8'h08, 10, 12);
    check("R9 untracked pin ignored", flags, 8'h00);
    outMode = 8'h08;
    pulse(8'h08, 10, 12);
    check("R9 output pin tracked", flags, 8'h08);
    digInEn = 8'hFF; outMode = 8'h00;
    clearFlags(8'hFF);

    // R7 stop-mode timebase
    stopMode = 1'b1; stopGenOn = 1'b1;
    cyc(8 - (cycCount % 8));
    pulse(8'h20, 10, 40);
    check("R7 run tick ignored in stop", flags, 8'h00);
    pulse(8'h20, 24, 40);
    check("R7 three stop ticks rejected", flags, 8'h00);
    pulse(8'h20, 32, 40);
    check("R7 four stop ticks accepted", flags, 8'h20);
    check("R8 wake in stop", wakeReq, 1'b1);
    stopMode = 1'b0; stopGenOn = 1'b0; stopTick = 1'b0;
    clearFlags(8'hFF);

    // R10 random rounds across pins, widths, enables
    for (int r = 0; r < 60; r++) begin
      logic [7:0] mask, clr, exp;
      int width;
      mask = 8'($urandom);
      width = 1 + int'($urandom % 8);
      edgeRising = 8'($urandom);
      irqEnable = 8'($urandom);
      pulse(mask, width, 12);
      exp = expFlags(mask, width);
      check("R10 random flags", flags, exp);
      check("R5 random irq", irqReq, expIrq(exp, irqEnable));
      clr = 8'($urandom);
      clearFlags(clr);
      check("R6 random clear", flags, exp & ~clr);
      clearFlags(8'hFF);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule